// File: doc/BRIEF.md
# Host Memory Cycle Router

This block decides, for every host memory cycle, whether the cycle is claimed by main DRAM or is passed on to the PCI bus. The decision is purely combinational from the 32-bit cycle address, a write flag and a flag that marks system-management-mode cycles. It is steered by a small set of configuration registers loaded through a write port.

Below 1 MB the map holds conventional memory, a fixed video window, and a legacy shadow area. The shadow area is cut into 16 KB segments (eight expansion segments and four extended BIOS segments), plus one 64 KB system BIOS segment. Each segment carries its own read and write enables, which lets firmware copy its ROM into DRAM and then run from DRAM. Above 1 MB, DRAM runs up to a programmable top of memory. Inside that span there are two carve-outs. The first is an optional fixed hole at 15 MB. The second is an optional SMRAM region directly under the top of memory, which only system-management cycles may reach. Address space that a carve-out or a disabled segment removes is never moved elsewhere.

Top module: `mem_cycle_router`

## Requirements
- R1: After reset every shadow attribute, the top of memory, the hole enable and the SMRAM enable are zero. Cycles from C0000h up to 4 GB-1 therefore go to PCI, and conventional memory still goes to DRAM.
- R2: Addresses 00000h–9FFFFh always go to DRAM.
- R3: Addresses A0000h–BFFFFh, which include the monochrome window B0000h–B7FFFh, always go to PCI.
- R4: Configuration register 0 holds the expansion attributes. Bits [2i+1:2i] are {write_en, read_en} for the segment at C0000h + i*16 KB, for i = 0..7. A read goes to DRAM only when read_en is set, and a write goes to DRAM only when write_en is set. Every other cycle goes to PCI.
- R5: Configuration register 1 bits [2j+1:2j] are {write_en, read_en} for the segment at E0000h + j*16 KB, for j = 0..3. They follow the same rule as R4.
- R6: Configuration register 1 bits [9:8] are {write_en, read_en} for the whole range F0000h–FFFFFh. They follow the same rule as R4.
- R7: Configuration register 2 bits [6:0] set the top of memory in units of 8 MB. Addresses from 100000h up to the top go to DRAM. Addresses from the top up to FFFFFFFFh go to PCI, and this includes both interrupt-controller windows FEC00000h and FEE00000h.
- R8: Configuration register 3 bit 0 enables the hole at F00000h–FFFFFFh. Cycles inside the hole go to PCI even when they lie below the top of memory.
- R9: Configuration register 3 bit 3 enables SMRAM, and bits [2:1] select its size: 0, 128 KB, 512 KB or 1 MB. SMRAM spans [top-size, top). A cycle inside SMRAM goes to PCI when smm_i is low and to DRAM when smm_i is high. The hole of R8 takes priority over SMRAM.
- R10: target_o is one-hot, with 01 meaning DRAM and 10 meaning PCI. It follows the address, the write flag and the mode inputs in the same cycle. A configuration write takes effect at the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register index |
| cfg_wdata_i | input | 16 | Configuration write data |
| addr_i | input | 32 | Host cycle byte address |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| smm_i | input | 1 | Cycle issued in system-management mode |
| target_o | output | 2 | One-hot target: 01 DRAM, 10 PCI |

## Verification
A wrong attribute bit, top-of-memory value or carve-out bound shows up as a flipped target_o. It appears in the very cycle an address in the affected range is presented, because no pipeline hides it. The bench therefore steps addresses across the edges of every segment, of the top of memory, of the hole and of SMRAM, with both read and write cycles and both mode values. After each configuration write it compares against a behavioural map on every clock.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM = 2'b01,
    TGT_PCI  = 2'b10
  } tgt_e;

  localparam logic [1:0] CFG_EXP  = 2'd0;
  localparam logic [1:0] CFG_BIOS = 2'd1;
  localparam logic [1:0] CFG_TOM  = 2'd2;
  localparam logic [1:0] CFG_CARV = 2'd3;

  localparam int SEG_SHIFT  = 14;   // 16 KB legacy segments
  localparam int TOM_SHIFT  = 23;   // 8 MB top-of-memory unit
endpackage

// File: rtl/mcr_cfg_regs.sv
module mcr_cfg_regs
  import mcr_pkg::*;
#(
  parameter int EXP_SEGS = 8,
  parameter int EXT_SEGS = 4,
  parameter int TOM_W    = 7,
  parameter int DATA_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [1:0]            sel_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [2*EXP_SEGS-1:0] exp_attr_o,
  output logic [2*EXT_SEGS-1:0] ext_attr_o,
  output logic [1:0]            sys_attr_o,
  output logic [TOM_W-1:0]      tom_o,
  output logic                  hole_en_o,
  output logic                  smram_en_o,
  output logic [1:0]            smram_sz_o
);
  localparam int SYS_LSB = 2 * EXT_SEGS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_attr_o <= '0;
      ext_attr_o <= '0;
      sys_attr_o <= '0;
      tom_o      <= '0;
      hole_en_o  <= 1'b0;
      smram_en_o <= 1'b0;
      smram_sz_o <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        CFG_EXP:  exp_attr_o <= wdata_i[2*EXP_SEGS-1:0];
        CFG_BIOS: begin
          ext_attr_o <= wdata_i[SYS_LSB-1:0];
          sys_attr_o <= wdata_i[SYS_LSB+1:SYS_LSB];
        end
        CFG_TOM:  tom_o <= wdata_i[TOM_W-1:0];
        CFG_CARV: begin
          hole_en_o  <= wdata_i[0];
          smram_sz_o <= wdata_i[2:1];
          smram_en_o <= wdata_i[3];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcr_legacy_dec.sv
module mcr_legacy_dec
  import mcr_pkg::*;
#(
  parameter int EXP_SEGS = 8,
  parameter int EXT_SEGS = 4
) (
  input  logic [5:0]            seg_i,   // addr[19:14]
  input  logic                  wr_i,
  input  logic [2*EXP_SEGS-1:0] exp_attr_i,
  input  logic [2*EXT_SEGS-1:0] ext_attr_i,
  input  logic [1:0]            sys_attr_i,
  output logic                  dram_o
);
  localparam int CONV_END_SEG = 'hA0000 >> SEG_SHIFT;
  localparam int EXP_BASE_SEG = 'hC0000 >> SEG_SHIFT;
  localparam int EXT_BASE_SEG = 'hE0000 >> SEG_SHIFT;

  logic [EXP_SEGS-1:0] exp_hit, exp_ok;
  logic [EXT_SEGS-1:0] ext_hit, ext_ok;
  logic                conv_hit, sys_hit, sys_ok;

  for (genvar i = 0; i < EXP_SEGS; i++) begin : g_exp
    assign exp_hit[i] = (seg_i == 6'(EXP_BASE_SEG + i));
    assign exp_ok[i]  = wr_i ? exp_attr_i[2*i+1] : exp_attr_i[2*i];
  end

  for (genvar j = 0; j < EXT_SEGS; j++) begin : g_ext
    assign ext_hit[j] = (seg_i == 6'(EXT_BASE_SEG + j));
    assign ext_ok[j]  = wr_i ? ext_attr_i[2*j+1] : ext_attr_i[2*j];
  end

  assign conv_hit = (seg_i < 6'(CONV_END_SEG));
  assign sys_hit  = (seg_i[5:2] == 4'hF);
  assign sys_ok   = wr_i ? sys_attr_i[1] : sys_attr_i[0];

  // video window A0000-BFFFF falls through to PCI
  assign dram_o = conv_hit | (|(exp_hit & exp_ok)) | (|(ext_hit & ext_ok))
                | (sys_hit & sys_ok);
endmodule

// File: rtl/mcr_ext_dec.sv
module mcr_ext_dec
  import mcr_pkg::*;
#(
  parameter int          TOM_W      = 7,
  parameter logic [31:0] HOLE_BASE  = 32'h00F0_0000,
  parameter logic [31:0] HOLE_LIMIT = 32'h00FF_FFFF
) (
  input  logic [31:0]      addr_i,
  input  logic             smm_i,
  input  logic [TOM_W-1:0] tom_i,
  input  logic             hole_en_i,
  input  logic             smram_en_i,
  input  logic [1:0]       smram_sz_i,
  output logic             dram_o
);
  logic [32:0] addr_w, tom_w, sm_size, sm_base;
  logic        below_tom, in_hole, in_smram;

  assign addr_w = {1'b0, addr_i};
  assign tom_w  = 33'(tom_i) << TOM_SHIFT;

  always_comb begin
    unique case (smram_sz_i)
      2'd0:    sm_size = 33'h0;
      2'd1:    sm_size = 33'h0_0002_0000;
      2'd2:    sm_size = 33'h0_0008_0000;
      default: sm_size = 33'h0_0010_0000;
    endcase
  end

  assign sm_base   = tom_w - sm_size;
  assign below_tom = addr_w < tom_w;
  assign in_hole   = hole_en_i && addr_i >= HOLE_BASE && addr_i <= HOLE_LIMIT;
  assign in_smram  = smram_en_i && addr_w >= sm_base;

  // nothing carved out is relocated: carve-outs just drop to PCI
  assign dram_o = below_tom && !in_hole && !(in_smram && !smm_i);
endmodule

// File: rtl/mem_cycle_router.sv
module mem_cycle_router
  import mcr_pkg::*;
#(
  parameter int EXP_SEGS = 8,
  parameter int EXT_SEGS = 4,
  parameter int TOM_W    = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [15:0] cfg_wdata_i,
  input  logic [31:0] addr_i,
  input  logic        wr_i,
  input  logic        smm_i,
  output logic [1:0]  target_o
);
  logic [2*EXP_SEGS-1:0] exp_attr;
  logic [2*EXT_SEGS-1:0] ext_attr;
  logic [1:0]            sys_attr;
  logic [TOM_W-1:0]      tom;
  logic                  hole_en, smram_en;
  logic [1:0]            smram_sz;
  logic                  low_mb, leg_dram, ext_dram;

  mcr_cfg_regs #(
    .EXP_SEGS(EXP_SEGS), .EXT_SEGS(EXT_SEGS), .TOM_W(TOM_W), .DATA_W(16)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .exp_attr_o (exp_attr),
    .ext_attr_o (ext_attr),
    .sys_attr_o (sys_attr),
    .tom_o      (tom),
    .hole_en_o  (hole_en),
    .smram_en_o (smram_en),
    .smram_sz_o (smram_sz)
  );

  mcr_legacy_dec #(.EXP_SEGS(EXP_SEGS), .EXT_SEGS(EXT_SEGS)) u_leg (
    .seg_i      (addr_i[19:14]),
    .wr_i       (wr_i),
    .exp_attr_i (exp_attr),
    .ext_attr_i (ext_attr),
    .sys_attr_i (sys_attr),
    .dram_o     (leg_dram)
  );

  mcr_ext_dec #(.TOM_W(TOM_W)) u_ext (
    .addr_i     (addr_i),
    .smm_i      (smm_i),
    .tom_i      (tom),
    .hole_en_i  (hole_en),
    .smram_en_i (smram_en),
    .smram_sz_i (smram_sz),
    .dram_o     (ext_dram)
  );

  assign low_mb   = (addr_i[31:20] == 12'h000);
  assign target_o = (low_mb ? leg_dram : ext_dram) ? TGT_DRAM : TGT_PCI;
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [31:0] addr_i,
  input logic        wr_i,
  input logic        smm_i,
  input logic [1:0]  sys_attr,
  input logic [1:0]  target_o
);
  // R10
  onehot_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(target_o) == 1);

  // R2
  conv_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 32'h000A_0000) |-> target_o == 2'b01);

  // R3
  video_pci_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 32'h000A_0000 && addr_i < 32'h000C_0000) |-> target_o == 2'b10);

  // R7
  apic_pci_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[31:20] == 12'hFEC || addr_i[31:20] == 12'hFEE) |-> target_o == 2'b10);

  // R6
  sys_bios_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[31:16] == 16'h000F && sys_attr == 2'b00) |-> target_o == 2'b10);

  // R10
  steady_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_i) && $stable(wr_i) && $stable(smm_i) && !$past(cfg_we_i))
      |-> $stable(target_o));
endmodule

bind mem_cycle_router mcr_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .smm_i    (smm_i),
  .sys_attr (sys_attr),
  .target_o (target_o)
);

// File: tb/mem_cycle_router_tb.sv
module mem_cycle_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] addr = '0;
  logic        wr = 1'b0;
  logic        smm = 1'b0;
  logic [1:0]  target;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  logic [15:0] m_exp = '0;
  logic [7:0]  m_ext = '0;
  logic [1:0]  m_sys = '0;
  int          m_tom = 0;
  bit          m_hole = 0, m_smen = 0;
  int          m_smsz = 0;
  bit          fresh = 1;

  always #10 clk = ~clk;

  mem_cycle_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .addr_i(addr), .wr_i(wr), .smm_i(smm),
    .target_o(target)
  );

  always @(posedge clk) begin
    if (rst_n && cfg_we) begin
      fresh <= 0;
      case (cfg_sel)
        2'd0: m_exp <= cfg_wdata;
        2'd1: begin m_ext <= cfg_wdata[7:0]; m_sys <= cfg_wdata[9:8]; end
        2'd2: m_tom <= int'(cfg_wdata[6:0]);
        default: begin
          m_hole <= cfg_wdata[0];
          m_smen <= cfg_wdata[3];
          m_smsz <= (cfg_wdata[2:1] == 2'd0) ? 0 :
                    (cfg_wdata[2:1] == 2'd1) ? 'h20000 :
                    (cfg_wdata[2:1] == 2'd2) ? 'h80000 : 'h100000;
        end
      endcase
    end
  end

  function automatic bit model_dram(longint a, bit w, bit s, output string tag);
    longint top = longint'(m_tom) * 64'h80_0000;
    int idx;
    if (a < 'hA0000) begin tag = "R2"; return 1; end
    if (a < 'hC0000) begin tag = "R3"; return 0; end
    if (a < 'hE0000) begin
      tag = "R4"; idx = int'((a - 'hC0000) / 'h4000);
      return w ? m_exp[2*idx+1] : m_exp[2*idx];
    end
    if (a < 'hF0000) begin
      tag = "R5"; idx = int'((a - 'hE0000) / 'h4000);
      return w ? m_ext[2*idx+1] : m_ext[2*idx];
    end
    if (a < 'h100000) begin tag = "R6"; return w ? m_sys[1] : m_sys[0]; end
    if (a >= top) begin tag = "R7"; return 0; end
    if (m_hole && a >= 'hF00000 && a <= 'hFFFFFF) begin tag = "R8"; return 0; end
    if (m_smen && a >= top - m_smsz) begin tag = "R9"; return s; end
    tag = "R7";
    return 1;
  endfunction

  // compare every clock, mid-cycle; R10: output reflects inputs driven this cycle
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      logic [1:0] exp_t;
      exp_t = model_dram(longint'(addr), wr, smm, tag) ? 2'b01 : 2'b10;
      if (fresh) tag = {"R1/", tag};
      checks++;
      if (target !== exp_t) begin
        failures++;
        $display("FAIL %s addr=%h wr=%0b smm=%0b actual=%b expected=%b",
                 tag, addr, wr, smm, target, exp_t);
      end
      checks++;
      if ($countones(target) != 1) begin
        failures++;
        $display("FAIL R10 one-hot actual=%b expected=one-hot", target);
      end
    end
  end

  task automatic access(input logic [31:0] a, input bit w, input bit s);
    @(posedge clk); #2;
    addr = a; wr = w; smm = s;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic sweep_legacy();
    for (int k = 0; k < 40; k++) begin
      access(32'h0009_C000 + 32'(k) * 32'h4000, 1'b0, 1'b0);
      access(32'h0009_FFFF + 32'(k) * 32'h4000, 1'b1, 1'b0);
    end
  endtask

  task automatic probe_ext();
    logic [31:0] pts [14] = '{32'h0010_0000, 32'h00EF_FFFF, 32'h00F0_0000,
      32'h00FF_FFFF, 32'h0100_0000, 32'h01E0_0000, 32'h01EF_FFFF,
      32'h01F8_0000, 32'h01FD_FFFF, 32'h01FE_0000, 32'h01FF_FFFF,
      32'h0200_0000, 32'hFEC0_0010, 32'hFEE0_0000};
    foreach (pts[i]) begin
      access(pts[i], 1'b0, 1'b0);
      access(pts[i], 1'b1, 1'b1);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset map
    sweep_legacy();
    probe_ext();
    // R4 varied segment attributes
    cfg_write(2'd0, 16'b11_00_10_01_00_11_10_01);
    sweep_legacy();
    // R5, R6
    cfg_write(2'd1, 16'b10_11_00_10_01);
    cfg_write(2'd1, {6'd0, 2'b11, 8'b01_10_00_11});
    sweep_legacy();
    cfg_write(2'd1, {6'd0, 2'b01, 8'b00_00_00_00});
    sweep_legacy();
    // R7 top at 32 MB
    cfg_write(2'd2, 16'd4);
    probe_ext();
    // R8 hole
    cfg_write(2'd3, 16'h0001);
    probe_ext();
    // R9 SMRAM 1 MB, 128 KB, 512 KB
    cfg_write(2'd3, 16'b1_11_0);
    probe_ext();
    cfg_write(2'd3, 16'b1_01_1);
    probe_ext();
    cfg_write(2'd3, 16'b1_10_0);
    probe_ext();
    // R8/R9 overlap at top 16 MB
    cfg_write(2'd2, 16'd2);
    cfg_write(2'd3, 16'b1_11_1);
    probe_ext();
    // R7 max top
    cfg_write(2'd2, 16'h7F);
    access(32'h3F7F_FFFF, 1'b0, 1'b0);
    access(32'h3F80_0000, 1'b0, 1'b0);
    access(32'hFFFF_FFFF, 1'b1, 1'b0);
    @(posedge clk); @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule